// File: doc/BRIEF.md
# Serial Burst Read Transmitter

This block answers a burst read command on the debug scan path. A command decoder hands it a start address, a word count and a word size of 8, 16 or 32 bits. The block then fetches the words over a simple request/acknowledge read port. It serialises each word onto the test data output, least significant bit first. Each shift strobe from the scan clock domain moves the output on by one bit.

In front of every word, the host polls a status bit. The block drives 0 while the next word has not yet arrived from the bus, then a single 1, then the data bits. Once the last word has gone out, the block sends a 32-bit checksum of every data bit it sent. After that it returns to idle and drives 0 for any further shifts. The next word is fetched as soon as the current one starts shifting, so a bus that answers quickly lets words follow with only one status bit each. A bus error sets a sticky error flag, which the shared error register logic clears, and the burst still completes.

Top module: `burst_read_tx`

## Requirements
- R1: After reset, `tdo`, `busy`, `busReq` and `errFlag` are all 0.
- R2: A start pulse is accepted only when the block is idle. On the clock cycle right after the accepting edge, `busReq` is low, so the first bus read waits at least one extra clock edge. Shifts in that cycle read 0.
- R3: Before each word, `tdo` reads 0 on every shift while the word is not yet buffered, and reads 1 exactly once when it is buffered. If a shift comes every cycle, the first word is preceded by exactly (bus latency + 2) zeros.
- R4: Right after the 1 status bit, the word is shifted out least significant bit first. The width follows the size code: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 gives 32 bits. Only the low bits of the bus data are used.
- R5: Bus reads go to the start address first, and the address rises by 1, 2 or 4 bytes per word according to the size, wrapping at the address width. `busSize` shows the size code of the command. A request holds its address until acknowledged. Exactly the commanded number of reads is made.
- R6: After the last word, 32 checksum bits are sent LSB first. The checksum starts at 0xFFFFFFFF. For each data bit b it becomes (c>>1) XOR (0xEDB88320 if b XOR c[0] else 0), and no final inversion is applied.
- R7: The next read is issued as soon as the current word has been loaded for shifting. With a zero-latency bus, every word after the first is preceded by a single 1 status bit and no zeros.
- R8: After the final checksum bit, `busy` is 0 and every further shift reads 0.
- R9: A start pulse while `busy` is 1 has no effect on the running burst: its data, addresses and checksum are unchanged.
- R10: An acknowledge with `busErr` high sets `errFlag`. The flag stays set until `errClr` is pulsed, and the burst carries on to the end.
- R11: A word count of 0 skips all bus reads and status bits: the first 32 shifts give 0xFFFFFFFF LSB first.
- R12: Cycles without `shiftEn` advance nothing: a 1 on `tdo` holds until shifted, and a bench with gaps between shifts sees the same stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan-domain clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Burst read command pulse from the decoder |
| startAddr | input | ADDR_W | First bus address of the burst |
| wordCount | input | CNT_W | Number of words to read |
| wordSize | input | 2 | Size code: 0 byte, 1 half word, 2 or 3 word |
| shiftEn | input | 1 | One pulse per shift of the data register |
| busReq | output | 1 | Bus read request, held until acknowledged |
| busAddr | output | ADDR_W | Bus read address |
| busSize | output | 2 | Size code of the read |
| busAck | input | 1 | Bus read completion |
| busErr | input | 1 | Bus error flag, valid with `busAck` |
| busData | input | 32 | Read data, right-aligned |
| errClr | input | 1 | Clears the sticky error flag |
| tdo | output | 1 | Serial output bit |
| busy | output | 1 | High from an accepted start until the last checksum bit |
| errFlag | output | 1 | Sticky bus error flag |

## Verification
The bench builds the block with a 16-bit address and a 4-bit word count. It sweeps all four size codes, word counts 0 to 4, bus latencies of 0, 1 and 3 cycles, and shift strobes either back-to-back or separated by idle cycles. The narrow address lets start addresses near the top of the space wrap within a burst. The short counts let every word, status run and checksum of each combination be compared against values the bench computes itself. The latency-0 runs expose single-bit status between prefetched words. The idle-cycle runs carry a stray start pulse and show that stalls change nothing.

// File: rtl/burst_read_pkg.sv
package burst_read_pkg;

  localparam int DATA_W = 32;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF;

  typedef struct packed {
    logic startCmd;
    logic arm;
    logic loadWord;
    logic shiftData;
    logic shiftCrc;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    OUT_ZERO,
    OUT_STATUS,
    OUT_DATA,
    OUT_CRC
  } outSel_e;

  function automatic logic [2:0] sizeBytes(input logic [1:0] code);
    case (code)
      2'd0: sizeBytes = 3'd1;
      2'd1: sizeBytes = 3'd2;
      default: sizeBytes = 3'd4;
    endcase
  endfunction

  function automatic logic [5:0] sizeBits(input logic [1:0] code);
    case (code)
      2'd0: sizeBits = 6'd8;
      2'd1: sizeBits = 6'd16;
      default: sizeBits = 6'd32;
    endcase
  endfunction

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c, input logic b);
    crcStep = (c >> 1) ^ ((b ^ c[0]) ? CRC_POLY : '0);
  endfunction

endpackage

// File: rtl/burst_read_ctrl.sv
module burst_read_ctrl
  import burst_read_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] wordCount,
  input  logic [1:0]       wordSize,
  input  logic             shiftEn,
  input  logic             bufValid,
  output ctrlStrobe_t      strobe,
  output outSel_e          outSel,
  output logic             busy
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_STATUS,
    ST_DATA,
    ST_CRC
  } state_e;

  localparam logic [5:0] CRC_LAST = 6'(CRC_W - 1);

  state_e           state;
  logic [CNT_W-1:0] wordsLeft;
  logic [5:0]       bitCnt;
  logic [1:0]       sizeReg;

  always_comb begin
    strobe = '0;
    outSel = OUT_ZERO;
    case (state)
      ST_IDLE:   strobe.startCmd = start;
      ST_ARM:    strobe.arm = 1'b1;
      ST_STATUS: begin
        outSel = OUT_STATUS;
        strobe.loadWord = shiftEn && bufValid;
      end
      ST_DATA: begin
        outSel = OUT_DATA;
        strobe.shiftData = shiftEn;
      end
      ST_CRC: begin
        outSel = OUT_CRC;
        strobe.shiftCrc = shiftEn;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      wordsLeft <= '0;
      bitCnt    <= '0;
      sizeReg   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          sizeReg   <= wordSize;
          wordsLeft <= wordCount;
          bitCnt    <= CRC_LAST;
          state     <= (wordCount == '0) ? ST_CRC : ST_ARM;
        end
        ST_ARM: state <= ST_STATUS;
        ST_STATUS: if (strobe.loadWord) begin
          bitCnt    <= sizeBits(sizeReg) - 6'd1;
          wordsLeft <= wordsLeft - 1'b1;
          state     <= ST_DATA;
        end
        ST_DATA: if (shiftEn) begin
          if (bitCnt == '0) begin
            bitCnt <= CRC_LAST;
            state  <= (wordsLeft == '0) ? ST_CRC : ST_STATUS;
          end else begin
            bitCnt <= bitCnt - 6'd1;
          end
        end
        ST_CRC: if (shiftEn) begin
          if (bitCnt == '0) state <= ST_IDLE;
          else bitCnt <= bitCnt - 6'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/burst_read_dp.sv
module burst_read_dp
  import burst_read_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  outSel_e           outSel,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic [1:0]        wordSize,
  input  logic              busAck,
  input  logic              busErr,
  input  logic [DATA_W-1:0] busData,
  input  logic              errClr,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic              bufValid,
  output logic              tdo,
  output logic              errFlag
);

  logic [ADDR_W-1:0] addrReg;
  logic [CNT_W-1:0]  readsLeft;
  logic [1:0]        sizeReg;
  logic              armed;
  logic [DATA_W-1:0] bufWord;
  logic [DATA_W-1:0] shifter;
  logic [CRC_W-1:0]  crcReg;
  logic              readDone;

  assign busReq   = armed && (readsLeft != '0) && !bufValid;
  assign readDone = busReq && busAck;
  assign busAddr  = addrReg;
  assign busSize  = sizeReg;

  // Fetch side: one-word prefetch buffer fed by the bus.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg   <= '0;
      readsLeft <= '0;
      sizeReg   <= '0;
      armed     <= 1'b0;
      bufValid  <= 1'b0;
      bufWord   <= '0;
    end else if (strobe.startCmd) begin
      addrReg   <= startAddr;
      readsLeft <= wordCount;
      sizeReg   <= wordSize;
      armed     <= 1'b0;
      bufValid  <= 1'b0;
    end else begin
      if (strobe.arm) armed <= 1'b1;
      if (readDone) begin
        bufWord   <= busData;
        bufValid  <= 1'b1;
        addrReg   <= addrReg + ADDR_W'(sizeBytes(sizeReg));
        readsLeft <= readsLeft - 1'b1;
      end else if (strobe.loadWord) begin
        bufValid <= 1'b0;
      end
    end
  end

  // Shift side: word shifter and running checksum.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shifter <= '0;
      crcReg  <= CRC_SEED;
    end else if (strobe.startCmd) begin
      crcReg <= CRC_SEED;
    end else if (strobe.loadWord) begin
      shifter <= bufWord;
    end else if (strobe.shiftData) begin
      crcReg  <= crcStep(crcReg, shifter[0]);
      shifter <= shifter >> 1;
    end else if (strobe.shiftCrc) begin
      crcReg <= crcReg >> 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errFlag <= 1'b0;
    else if (readDone && busErr) errFlag <= 1'b1;
    else if (errClr) errFlag <= 1'b0;
  end

  always_comb begin
    case (outSel)
      OUT_STATUS: tdo = bufValid;
      OUT_DATA:   tdo = shifter[0];
      OUT_CRC:    tdo = crcReg[0];
      default:    tdo = 1'b0;
    endcase
  end

endmodule

// File: rtl/burst_read_tx.sv
module burst_read_tx
  import burst_read_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic [1:0]        wordSize,
  input  logic              shiftEn,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  input  logic              busAck,
  input  logic              busErr,
  input  logic [31:0]       busData,
  input  logic              errClr,
  output logic              tdo,
  output logic              busy,
  output logic              errFlag
);

  ctrlStrobe_t strobe;
  outSel_e     outSel;
  logic        bufValid;

  burst_read_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .wordCount (wordCount),
    .wordSize  (wordSize),
    .shiftEn   (shiftEn),
    .bufValid  (bufValid),
    .strobe    (strobe),
    .outSel    (outSel),
    .busy      (busy)
  );

  burst_read_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .outSel    (outSel),
    .startAddr (startAddr),
    .wordCount (wordCount),
    .wordSize  (wordSize),
    .busAck    (busAck),
    .busErr    (busErr),
    .busData   (busData),
    .errClr    (errClr),
    .busReq    (busReq),
    .busAddr   (busAddr),
    .busSize   (busSize),
    .bufValid  (bufValid),
    .tdo       (tdo),
    .errFlag   (errFlag)
  );

endmodule

// File: rtl/burst_read_tx_chk.sv
module burst_read_tx_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              shiftEn,
  input logic              busReq,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        busSize,
  input logic              busAck,
  input logic              busErr,
  input logic              errClr,
  input logic              tdo,
  input logic              busy,
  input logic              errFlag
);

  p_no_req_after_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> !busReq);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!tdo && !busReq));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busAddr) && $stable(busSize)));

  p_err_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busAck && busErr) |=> errFlag);

  p_err_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClr) |=> errFlag);

  p_hold_one_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !shiftEn && tdo) |=> tdo);

endmodule

bind burst_read_tx burst_read_tx_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/burst_read_tx_tb.sv
module burst_read_tx_tb;

  localparam int ADDR_W = 16;
  localparam int CNT_W  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [CNT_W-1:0]  wordCount = '0;
  logic [1:0]        wordSize = '0;
  logic              shiftEn = 1'b0;
  logic              busReq;
  logic [ADDR_W-1:0] busAddr;
  logic [1:0]        busSize;
  logic              busAck = 1'b0;
  logic              busErr = 1'b0;
  logic [31:0]       busData = '0;
  logic              errClr = 1'b0;
  logic              tdo;
  logic              busy;
  logic              errFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int cycles = 0;

  // bus model context
  int                lat = 0;
  int                waitCnt = 0;
  int                readIdx = 0;
  logic [ADDR_W-1:0] runBase = '0;
  logic [1:0]        runSize = '0;
  bit                errEn = 0;
  logic [ADDR_W-1:0] errAddr = '0;

  always #2 clk = ~clk;

  burst_read_tx #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] memWord(input logic [ADDR_W-1:0] a);
    memWord = ({16'h0, a} * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic int bytesOf(input logic [1:0] s);
    bytesOf = (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] crcBit(input logic [31:0] c, input logic b);
    crcBit = (c >> 1) ^ ((b ^ c[0]) ? 32'hEDB88320 : 32'h0);
  endfunction

  // Bus slave: answers after lat waiting cycles, checks each address (R5)
  always @(negedge clk) begin
    busAck = 1'b0;
    busErr = 1'b0;
    if (busReq) begin
      if (waitCnt >= lat) begin
        logic [ADDR_W-1:0] expA;
        expA = runBase + ADDR_W'(readIdx * bytesOf(runSize));
        check(busAddr == expA, "R5 address", 32'(busAddr), 32'(expA));
        check(busSize == runSize, "R5 size", 32'(busSize), 32'(runSize));
        busAck  = 1'b1;
        busData = memWord(busAddr);
        busErr  = errEn && (busAddr == errAddr);
        readIdx++;
        waitCnt = 0;
      end else begin
        waitCnt++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic shiftBit(output logic b, input int gap);
    b = tdo;
    shiftEn = 1'b1;
    @(negedge clk);
    shiftEn = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic runBurst(input logic [1:0] sz, input int cnt, input logic [ADDR_W-1:0] base,
                          input int gap, input bit wantErr);
    logic [31:0] expCrc;
    logic [31:0] word;
    logic [31:0] got;
    logic b;
    int zeros;
    int nb;
    expCrc  = 32'hFFFFFFFF;
    nb      = bytesOf(sz) * 8;
    runBase = base;
    runSize = sz;
    readIdx = 0;
    waitCnt = 0;
    errEn   = wantErr;
    errAddr = base + ADDR_W'(bytesOf(sz));
    start = 1'b1; startAddr = base; wordCount = CNT_W'(cnt); wordSize = sz;
    @(negedge clk);
    start = 1'b0;
    check(busReq == 1'b0, "R2 no read in arming cycle", 32'(busReq), 0);
    if (cnt == 0) begin
      got = '0;
      for (int i = 0; i < 32; i++) begin shiftBit(b, gap); got[i] = b; end
      check(got == 32'hFFFFFFFF, "R11 empty burst checksum", got, 32'hFFFFFFFF);
      check(readIdx == 0, "R11 no bus read", 32'(readIdx), 0);
    end else begin
      for (int w = 0; w < cnt; w++) begin
        zeros = 0;
        b = 1'b0;
        while (!b && zeros < 200) begin
          shiftBit(b, gap);
          if (!b) zeros++;
        end
        check(b == 1'b1, "R3 status one", 32'(b), 1);
        if (w == 0 && gap == 0) check(zeros == lat + 2, "R3 first status run", 32'(zeros), 32'(lat + 2));
        if (w > 0 && lat == 0) check(zeros == 0, "R7 prefetch single status", 32'(zeros), 0);
        if (w == 0 && gap != 0) begin
          // R9: stray command while busy
          start = 1'b1; startAddr = base + 16'h0100; wordCount = CNT_W'(1); wordSize = sz + 2'd1;
          @(negedge clk);
          start = 1'b0;
        end
        word = '0;
        for (int i = 0; i < nb; i++) begin
          shiftBit(b, gap);
          word[i] = b;
          expCrc = crcBit(expCrc, b);
        end
        got = memWord(base + ADDR_W'(w * bytesOf(sz)));
        if (nb < 32) got = got & ((32'h1 << nb) - 1);
        check(word == got, (gap != 0) ? "R4 R12 data word" : "R4 data word", word, got);
      end
      got = '0;
      for (int i = 0; i < 32; i++) begin shiftBit(b, gap); got[i] = b; end
      check(got == expCrc, (gap != 0) ? "R6 R9 checksum" : "R6 checksum", got, expCrc);
      check(readIdx == cnt, "R5 read count", 32'(readIdx), 32'(cnt));
    end
    check(busy == 1'b0, "R8 idle after checksum", 32'(busy), 0);
    got = '0;
    for (int i = 0; i < 8; i++) begin shiftBit(b, 0); got[i] = b; end
    check(got == 0, "R8 trailing zeros", got, 0);
    if (wantErr) begin
      check(errFlag == 1'b1, "R10 error sticky", 32'(errFlag), 1);
      errClr = 1'b1;
      @(negedge clk);
      errClr = 1'b0;
      check(errFlag == 1'b0, "R10 error cleared", 32'(errFlag), 0);
    end else begin
      check(errFlag == 1'b0, "R10 no error", 32'(errFlag), 0);
    end
  endtask

  initial begin
    int run;
    run = 0;
    repeat (3) @(negedge clk);
    check(tdo == 1'b0 && busy == 1'b0, "R1 reset outputs", {30'h0, tdo, busy}, 0);
    check(busReq == 1'b0 && errFlag == 1'b0, "R1 reset bus/error", {30'h0, busReq, errFlag}, 0);
    rstN = 1'b1;
    @(negedge clk);
    foreach (lats[li]) ;
    for (int li = 0; li < 3; li++) begin
      lat = (li == 0) ? 0 : (li == 1) ? 1 : 3;
      for (int gap = 0; gap < 2; gap++) begin
        for (int sz = 0; sz < 4; sz++) begin
          for (int cnt = 0; cnt < 5; cnt++) begin
            runBurst(2'(sz), cnt, ADDR_W'(16'hFFF0 + run * 7), gap, (lat == 1) && (cnt >= 2));
            run++;
          end
        end
      end
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int lats[3] = '{0, 1, 3};

endmodule